// File: doc/BRIEF.md
# Background Interstage Gain Calibrator

This block calibrates the interstage gain of the first stage of a pipelined converter while the converter keeps running. The first stage resolves a 1.5-bit decision and hands its amplified residue to a backend, which returns a signed word. The block joins the two into one output word. The backend word is scaled by an adaptive digital coefficient, and the coefficient's ideal value is the reciprocal of one minus the residue amplifier's relative gain error.

A pseudo-random ±1 test bit is presented to the analog stage. The stage adds a quarter of full scale, with that sign, to its residue. On the digital side the block removes the ideal test contribution from every output word. A gain mismatch therefore leaves a residual that is correlated with the test sequence. The block accumulates the product of output and test sign over a long block of samples. At the end of the block it nudges the coefficient by one step against the sign of that sum, and it clears the sum. Normal conversion is never interrupted.

Top module: `tsGainCal`

## Requirements
- R1: For each accepted sample the output is d*2^(BE_W-1) + floor(b*k/2^FRAC_W) - t*2^(BE_W-3). Here b is the signed backend word and k is the coefficient. The stage code sets d: 2'b00 is -1, 2'b01 is 0, 2'b10 is +1, and the reserved 2'b11 is 0. The test sign t is +1 when the test bit is 1 and -1 when it is 0.
- R2: `outValid` is high exactly one cycle after an accepted sample, and `calOut` then shows that sample's result. On every other cycle `calOut` holds its value.
- R3: The test bit is bit 0 of an LFSR_W-bit register. Each accepted sample shifts the register right by one and loads the parity of (state AND LFSR_TAPS) into the top bit. A sample uses the test bit that is shown while it is presented.
- R4: The test-sequence register never holds zero.
- R5: Each accepted sample adds t times its output value to a correlation sum. A block is 2^BLOCK_LOG2 accepted samples.
- R6: On the last sample of a block, the sum that includes that sample decides the update. A positive sum lowers the coefficient by 2^(FRAC_W-STEP_SHIFT) LSBs, a negative sum raises it by the same amount, and zero leaves it as it is. The sum then restarts from zero. The coefficient changes at no other time.
- R7: The coefficient saturates within [0.75, 1.25], that is [3*2^(FRAC_W-2), 5*2^(FRAC_W-2)] LSBs.
- R8: After synchronous reset the coefficient is exactly 1.0 (2^FRAC_W), `outValid` and `calOut` are 0, and the test bit is bit 0 of LFSR_SEED.
- R9: If the stage gain error puts the ideal coefficient inside the saturation range, the coefficient settles within two steps of that ideal value.
- R10: Cycles with `inValid` low do not advance the test sequence, the block count or the correlation sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample strobe for stageCode and backendWord |
| stageCode | input | 2 | First-stage decision code |
| backendWord | input | BE_W | Signed backend conversion word |
| testBit | output | 1 | Test sign for the analog stage (1 = +quarter scale) |
| outValid | output | 1 | Calibrated word valid |
| calOut | output | BE_W+2 | Signed calibrated output word |
| gainCoef | output | FRAC_W+1 | Current coefficient, unsigned, FRAC_W fraction bits |

## Verification
Some properties are checked by assertions on every cycle. These are the coefficient range, that the coefficient moves only at a block end and by at most one step, that the sum is cleared after a block end, the output strobe timing and holding, and that the test-sequence register is non-zero and frozen when no sample arrives. Other behaviour can only be shown by the bench's scenarios, which drive an emulated stage with a chosen gain error. These are the exact output arithmetic for each stage code, the sign convention of the update, the exact coefficient trajectory, and settling near the ideal value or pinning at either limit.

// File: rtl/tsgc_pkg.sv
package tsgc_pkg;

  typedef enum logic [1:0] {
    CODE_NEG  = 2'b00,
    CODE_ZERO = 2'b01,
    CODE_POS  = 2'b10,
    CODE_RSVD = 2'b11
  } stageCode_e;

  typedef struct packed {
    logic take;      // sample accepted this cycle
    logic blockEnd;  // this sample closes a correlation block
  } calStrobe_t;

endpackage

// File: rtl/tsGen.sv
module tsGen #(
  parameter int          LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'h002D,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output logic testBit
);

  logic [LFSR_W-1:0] lfsrState;
  logic              feedback;

  assign feedback = ^(lfsrState & LFSR_TAPS);
  assign testBit  = lfsrState[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsrState <= LFSR_SEED;
    end else if (advance) begin
      lfsrState <= {feedback, lfsrState[LFSR_W-1:1]};
    end
  end

  // R4: the sequence register must never collapse to zero
  a_r4_state_nonzero: assert property (@(posedge clk) disable iff (rst)
    lfsrState != '0);

  // R10: no accepted sample, no movement of the sequence
  a_r10_seq_frozen: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(lfsrState));

endmodule

// File: rtl/calCtrl.sv
module calCtrl
  import tsgc_pkg::*;
#(
  parameter int BLOCK_LOG2 = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output calStrobe_t strobe
);

  logic [BLOCK_LOG2-1:0] sampleCnt;
  logic                  lastOfBlock;

  assign lastOfBlock     = &sampleCnt;
  assign strobe.take     = inValid;
  assign strobe.blockEnd = inValid && lastOfBlock;

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleCnt <= '0;
    end else if (inValid) begin
      sampleCnt <= sampleCnt + 1'b1;
    end
  end

  // R5: a block end restarts the sample count
  a_r5_count_wraps: assert property (@(posedge clk) disable iff (rst)
    strobe.blockEnd |=> sampleCnt == '0);

  // R10: idle cycles do not count
  a_r10_count_idle: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(sampleCnt));

endmodule

// File: rtl/calDatapath.sv
module calDatapath
  import tsgc_pkg::*;
#(
  parameter int BE_W       = 12,
  parameter int FRAC_W     = 14,
  parameter int STEP_SHIFT = 8,
  parameter int BLOCK_LOG2 = 20,
  localparam int OUT_W     = BE_W + 2,
  localparam int CW        = FRAC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  calStrobe_t       strobe,
  input  logic [1:0]       stageCode,
  input  logic [BE_W-1:0]  backendWord,
  input  logic             testBit,
  output logic             outValid,
  output logic [OUT_W-1:0] calOut,
  output logic [CW-1:0]    gainCoef
);

  localparam int PW    = BE_W + CW + 1;
  localparam int ACC_W = OUT_W + BLOCK_LOG2 + 1;

  localparam logic signed [OUT_W-1:0] HALF_FS = OUT_W'(2 ** (BE_W - 1));
  localparam logic signed [OUT_W-1:0] QTR_FS  = OUT_W'(2 ** (BE_W - 3));

  localparam logic [CW-1:0] COEF_ONE  = CW'(2 ** FRAC_W);
  localparam logic [CW-1:0] COEF_MIN  = CW'(3 * (2 ** (FRAC_W - 2)));
  localparam logic [CW-1:0] COEF_MAX  = CW'(5 * (2 ** (FRAC_W - 2)));
  localparam logic [CW-1:0] COEF_STEP = CW'(2 ** (FRAC_W - STEP_SHIFT));

  logic signed [PW-1:0]    beExt, coefExt, prod;
  logic signed [OUT_W-1:0] scaled, stageTerm, testTerm, yNow;
  logic signed [ACC_W-1:0] yExt, contrib, accSum, acc;
  logic [CW-1:0]           coef, coefNext, coefUp, coefDown;
  stageCode_e              code;

  // scaling of the backend word by the coefficient
  assign beExt   = {{(PW - BE_W){backendWord[BE_W-1]}}, backendWord};
  assign coefExt = {{(PW - CW){1'b0}}, coef};
  assign prod    = beExt * coefExt;
  assign scaled  = OUT_W'(prod >>> FRAC_W);

  // first-stage contribution
  assign code = stageCode_e'(stageCode);
  always_comb begin
    unique case (code)
      CODE_NEG: stageTerm = -HALF_FS;
      CODE_POS: stageTerm = HALF_FS;
      default:  stageTerm = '0;
    endcase
  end

  // known test contribution removed at output scale
  assign testTerm = testBit ? QTR_FS : -QTR_FS;
  assign yNow     = stageTerm + scaled - testTerm;

  // correlation with the test sign
  assign yExt    = {{(ACC_W - OUT_W){yNow[OUT_W-1]}}, yNow};
  assign contrib = testBit ? yExt : -yExt;
  assign accSum  = acc + contrib;

  // sign-driven coefficient step with saturation
  assign coefDown = (coef < COEF_MIN + COEF_STEP) ? COEF_MIN : coef - COEF_STEP;
  assign coefUp   = (coef > COEF_MAX - COEF_STEP) ? COEF_MAX : coef + COEF_STEP;

  always_comb begin
    coefNext = coef;
    if (strobe.blockEnd) begin
      if (accSum > 0) begin
        coefNext = coefDown;
      end else if (accSum < 0) begin
        coefNext = coefUp;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      coef     <= COEF_ONE;
      outValid <= 1'b0;
      calOut   <= '0;
    end else begin
      outValid <= strobe.take;
      coef     <= coefNext;
      if (strobe.take) begin
        calOut <= yNow;
        acc    <= strobe.blockEnd ? '0 : accSum;
      end
    end
  end

  assign gainCoef = coef;

  // R7: coefficient stays inside its saturation window
  a_r7_coef_range: assert property (@(posedge clk) disable iff (rst)
    coef >= COEF_MIN && coef <= COEF_MAX);

  // R6: the coefficient only moves at a block end
  a_r6_coef_block_only: assert property (@(posedge clk) disable iff (rst)
    !strobe.blockEnd |=> $stable(coef));

  // R6: a block end moves the coefficient by at most one step
  a_r6_one_step: assert property (@(posedge clk) disable iff (rst)
    strobe.blockEnd |=> (coef == $past(coef)) || (coef == $past(coef) + COEF_STEP)
                     || (coef == $past(coef) - COEF_STEP)
                     || (coef == COEF_MIN) || (coef == COEF_MAX));

  // R5: the correlation sum restarts after a block
  a_r5_acc_cleared: assert property (@(posedge clk) disable iff (rst)
    strobe.blockEnd |=> acc == '0);

  // R2: output strobe follows the accepted sample by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    strobe.take |=> outValid);

  // R2: output word holds between samples
  a_r2_output_holds: assert property (@(posedge clk) disable iff (rst)
    !strobe.take |=> !outValid && $stable(calOut));

  // R10: idle cycles leave the sum untouched
  a_r10_acc_idle: assert property (@(posedge clk) disable iff (rst)
    !strobe.take |=> $stable(acc));

endmodule

// File: rtl/tsGainCal.sv
module tsGainCal
  import tsgc_pkg::*;
#(
  parameter int                BE_W       = 12,
  parameter int                FRAC_W     = 14,
  parameter int                STEP_SHIFT = 8,
  parameter int                BLOCK_LOG2 = 20,
  parameter int                LFSR_W     = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS  = 16'h002D,
  parameter logic [LFSR_W-1:0] LFSR_SEED  = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        stageCode,
  input  logic [BE_W-1:0]   backendWord,
  output logic              testBit,
  output logic              outValid,
  output logic [BE_W+1:0]   calOut,
  output logic [FRAC_W:0]   gainCoef
);

  calStrobe_t strobe;

  calCtrl #(
    .BLOCK_LOG2(BLOCK_LOG2)
  ) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .inValid(inValid),
    .strobe (strobe)
  );

  tsGen #(
    .LFSR_W   (LFSR_W),
    .LFSR_TAPS(LFSR_TAPS),
    .LFSR_SEED(LFSR_SEED)
  ) uGen (
    .clk    (clk),
    .rst    (rst),
    .advance(strobe.take),
    .testBit(testBit)
  );

  calDatapath #(
    .BE_W      (BE_W),
    .FRAC_W    (FRAC_W),
    .STEP_SHIFT(STEP_SHIFT),
    .BLOCK_LOG2(BLOCK_LOG2)
  ) uDp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .stageCode  (stageCode),
    .backendWord(backendWord),
    .testBit    (testBit),
    .outValid   (outValid),
    .calOut     (calOut),
    .gainCoef   (gainCoef)
  );

endmodule

// File: tb/tb_tsGainCal.sv
`timescale 1ns/1ps
module tb_tsGainCal;

  localparam int BE_W = 12, FRAC_W = 14, STEP_SHIFT = 6, BLOCK_LOG2 = 9;
  localparam int BLK = 2 ** BLOCK_LOG2;
  localparam longint ONE = 2 ** FRAC_W, STEP = 2 ** (FRAC_W - STEP_SHIFT);
  localparam longint CMIN = 3 * (2 ** (FRAC_W - 2)), CMAX = 5 * (2 ** (FRAC_W - 2));
  localparam logic [15:0] TAPS = 16'h002D, SEED = 16'hACE1;

  logic clk = 1'b0, rst = 1'b1, inValid = 1'b0;
  logic [1:0] stageCode = 2'b01;
  logic [BE_W-1:0] backendWord = '0;
  logic testBit, outValid;
  logic [BE_W+1:0] calOut;
  logic [FRAC_W:0] gainCoef;

  tsGainCal #(.BE_W(BE_W), .FRAC_W(FRAC_W), .STEP_SHIFT(STEP_SHIFT),
              .BLOCK_LOG2(BLOCK_LOG2), .LFSR_W(16), .LFSR_TAPS(TAPS),
              .LFSR_SEED(SEED)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .stageCode(stageCode),
    .backendWord(backendWord), .testBit(testBit), .outValid(outValid),
    .calOut(calOut), .gainCoef(gainCoef));

  always #2.5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // reference model state
  logic [15:0] mLfsr;
  longint mCoef, mAcc, expY;
  int mCnt;
  bit pendValid;

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint stageVal(input logic [1:0] c);
    case (c)
      2'b00: return -1;
      2'b10: return 1;
      default: return 0;   // 01 and reserved 11
    endcase
  endfunction

  function automatic longint modelOut(input logic [1:0] c, input longint be, input longint coef, input longint t);
    return stageVal(c) * (2 ** (BE_W - 1)) + ((be * coef) >>> FRAC_W) - t * (2 ** (BE_W - 3));
  endfunction

  // emulated stage: residue plus injected test term, amplified with gain error
  function automatic int mkBe(input int r, input real ge);
    real t, v;
    int b;
    t = mLfsr[0] ? 1.0 : -1.0;
    v = (r + t * (2.0 ** (BE_W - 3))) * (1.0 - ge);
    b = $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
    if (b > 2 ** (BE_W - 1) - 1) b = 2 ** (BE_W - 1) - 1;
    if (b < -(2 ** (BE_W - 1))) b = -(2 ** (BE_W - 1));
    return b;
  endfunction

  task automatic modelReset();
    mLfsr = SEED; mCoef = ONE; mAcc = 0; mCnt = 0; expY = 0; pendValid = 0;
  endtask

  task automatic doReset();
    rst = 1'b1; inValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
    // R8: reset state
    chk("R8 coef", longint'(gainCoef), ONE);
    chk("R8 outValid", longint'(outValid), 0);
    chk("R8 calOut", longint'($signed(calOut)), 0);
    chk("R8 testBit", longint'(testBit), longint'(SEED[0]));
  endtask

  // one cycle: check last cycle's results, then drive this one
  task automatic step(input bit v, input logic [1:0] code, input int be);
    longint t, y;
    @(negedge clk);
    chk("R2 outValid", longint'(outValid), longint'(pendValid));
    chk("R1 calOut", longint'($signed(calOut)), expY);
    chk("R6 coef", longint'(gainCoef), mCoef);
    chk("R3 testBit", longint'(testBit), longint'(mLfsr[0]));
    inValid = v; stageCode = code; backendWord = BE_W'(be);
    pendValid = v;
    if (v) begin
      t = mLfsr[0] ? 1 : -1;
      y = modelOut(code, longint'(be), mCoef, t);
      expY = y;
      mAcc += t * y;
      mCnt++;
      mLfsr = {^(mLfsr & TAPS), mLfsr[15:1]};
      if (mCnt == BLK) begin
        if (mAcc > 0) mCoef = (mCoef - STEP < CMIN) ? CMIN : mCoef - STEP;
        else if (mAcc < 0) mCoef = (mCoef + STEP > CMAX) ? CMAX : mCoef + STEP;
        mAcc = 0; mCnt = 0;
      end
    end
  endtask

  task automatic runBlocks(input int nBlk, input real ge, input bit randCode, input int gapPct, input int rAmp);
    int total;
    total = 0;
    while (total < nBlk * BLK) begin
      if ($urandom_range(99) < gapPct) begin
        // R10: idle cycle with junk on the data inputs
        step(1'b0, 2'($urandom_range(3)), int'($urandom_range(4095)) - 2048);
      end else begin
        step(1'b1, randCode ? 2'($urandom_range(3)) : 2'b01,
             mkBe(int'($urandom_range(2 * rAmp)) - rAmp, ge));
        total++;
      end
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    longint ideal, diff;
    void'($urandom(32'd20240611));
    doReset();

    // R1 directed: every stage code with extreme backend words, including reserved 11
    step(1'b1, 2'b00, 2047);
    step(1'b1, 2'b01, -2048);
    step(1'b1, 2'b10, 2047);
    step(1'b1, 2'b11, -1);
    step(1'b0, 2'b10, 100);   // R10/R2: idle, output must hold
    step(1'b0, 2'b00, -100);
    step(1'b1, 2'b10, 0);
    step(1'b1, 2'b00, -2048);

    // R5/R6/R10: random codes, random gaps, exact trajectory vs model
    runBlocks(4, 0.05, 1'b1, 30, 600);

    // R9: convergence toward 1/(1-Ge)
    runBlocks(40, 0.1, 1'b0, 3, 32);
    step(1'b0, 2'b01, 0);
    ideal = longint'($rtoi(real'(ONE) / 0.9));
    diff = longint'(gainCoef) - ideal;
    if (diff < 0) diff = -diff;
    chk("R9 settle within 2 steps", (diff <= 2 * STEP) ? 1 : 0, 1);

    // R7: ideal above range pins at 1.25
    doReset();
    runBlocks(30, 0.3, 1'b0, 3, 32);
    step(1'b0, 2'b01, 0);
    chk("R7 upper limit", longint'(gainCoef), CMAX);

    // R7: ideal below range pins at 0.75
    doReset();
    runBlocks(30, -0.4, 1'b0, 3, 32);
    step(1'b0, 2'b01, 0);
    chk("R7 lower limit", longint'(gainCoef), CMIN);

    // R1 at the saturated coefficient with extreme words
    step(1'b1, 2'b10, 2047);
    step(1'b1, 2'b00, -2048);
    step(1'b0, 2'b01, 0);

    done = 1;
    summary();
  end

endmodule